// File: doc/BRIEF.md
# DRAM refresh and self-refresh sequencer

This synchronous block keeps an asynchronous DRAM of `ROWS` rows refreshed on behalf of a memory controller. After a power-up start it waits a settling time, then asks for a short run of wake-up refreshes. Only after that does it raise `ready`. In normal operation it paces distributed CAS-before-RAS refresh requests at a fixed interval. Intervals that the controller has not yet served are counted, up to a ceiling. If no refresh completes for a whole retention period, the block drops `ready` and runs the wake-up sequence again.

On request the block puts the device into self refresh by holding a drive command (RAS and CAS held low) for at least a minimum time. When told to leave, it releases the drive command and waits out a recovery time. If `exit_burst` shows that the controller did not use distributed refresh, it then asks for a refresh of every row before normal operation resumes. All timing limits are parameters given in clock cycles. The controller owns the pins: it answers `ref_req` with a one-cycle `ref_gnt` and later reports completion with `ref_done`.

Top module: `dram_refresh_seq`

## Requirements
- R1: After reset `ready`, `ref_req` and `sr_drive` are 0, and they stay 0 until `pwr_start` is seen.
- R2: After `pwr_start` is sampled, no request is made for `PWRUP_WAIT` cycles. Then `ref_req` rises, and `ready` rises in the cycle after the `WAKE_CYCLES`-th `ref_done`, not earlier.
- R3: `ref_req` stays high until `ref_gnt` is sampled with it. It is low while the granted refresh is in flight, up to and including the cycle in which `ref_done` is sampled.
- R4: In normal operation `ref_req` rises `REF_INTERVAL` cycles after `ready` rises. It also rises `REF_INTERVAL` cycles after the edge that sampled the last grant.
- R5: Unserved intervals accumulate and saturate at `PEND_MAX`. After many missed intervals, exactly `PEND_MAX` back-to-back refreshes are requested.
- R6: If no refresh completes for `STALE_LIMIT` cycles of normal operation, `ready` falls and the `WAKE_CYCLES` wake-up refreshes are requested again before `ready` returns.
- R7: `sleep_enter` sampled in normal operation with no refresh in flight raises `sr_drive` at that edge. `ready` and `ref_req` are low while `sr_drive` is high.
- R8: `sleep_enter` sampled while a refresh is in flight is remembered. `sr_drive` rises one cycle after the edge that samples `ref_done`.
- R9: `sr_drive` stays high for exactly `SR_HOLD` cycles when exit is requested early. A `sleep_exit` pulse in the hold time is remembered.
- R10: After `sr_drive` falls, `ready` and `ref_req` stay low for `EXIT_RECOVER` cycles.
- R11: If `exit_burst` is 1 at the end of recovery, `ROWS` refreshes are requested and `ready` rises only after the last of them completes. If it is 0, `ready` rises directly.
- R12: `sleep_exit` outside self refresh and `sleep_enter` during the wake-up sequence have no effect. `sr_drive` stays 0 and `ready` follows its normal course.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_start | input | 1 | Starts the power-up sequence |
| sleep_enter | input | 1 | Request to enter self refresh |
| sleep_exit | input | 1 | Request to leave self refresh |
| exit_burst | input | 1 | 1 = refresh all rows after leaving self refresh |
| ref_gnt | input | 1 | Controller accepts the pending refresh request |
| ref_done | input | 1 | Controller finished the granted refresh |
| ref_req | output | 1 | Refresh request to the controller |
| sr_drive | output | 1 | Hold RAS and CAS low for self refresh |
| ready | output | 1 | Normal accesses allowed |

## Verification
The hardest situation to reach is a sleep request that arrives while a refresh is granted but not yet finished. Here the entry must be deferred exactly to the cycle after `ref_done`. The bench waits for a paced request, grants it, and pulses `sleep_enter` during the in-flight window before it answers with `ref_done`. The same session then leaves self refresh with `exit_burst` set, so the full row burst is driven after the recovery count. The watchdog-driven return to wake-up is reached by withholding grants for a full retention period after the saturation test.

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int ROWS         = 1024,
  parameter int WAKE_CYCLES  = 8,
  parameter int PWRUP_WAIT   = 20000,
  parameter int REF_INTERVAL = 3120,
  parameter int PEND_MAX     = 8,
  parameter int STALE_LIMIT  = 3200000,
  parameter int SR_HOLD      = 20000,
  parameter int EXIT_RECOVER = 21
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_start,
  input  logic sleep_enter,
  input  logic sleep_exit,
  input  logic exit_burst,
  input  logic ref_gnt,
  input  logic ref_done,
  output logic ref_req,
  output logic sr_drive,
  output logic ready
);
  localparam int M1   = (PWRUP_WAIT > SR_HOLD) ? PWRUP_WAIT : SR_HOLD;
  localparam int M2   = (ROWS > EXIT_RECOVER) ? ROWS : EXIT_RECOVER;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int CMAX = (M3 > WAKE_CYCLES) ? M3 : WAKE_CYCLES;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int IW   = $clog2(REF_INTERVAL + 1);
  localparam int SW   = $clog2(STALE_LIMIT + 1);
  localparam int PW   = $clog2(PEND_MAX + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_PWAIT, S_WAKE, S_RUN, S_SR, S_EXREC, S_BURST
  } state_t;

  state_t st;
  logic [CW-1:0] cnt;
  logic [IW-1:0] ival;
  logic [SW-1:0] stale;
  logic [PW-1:0] pend;
  logic inflight, sleep_pend, exit_pend;

  wire run      = (st == S_RUN);
  wire seq      = (st == S_WAKE) || (st == S_BURST);
  assign ref_req  = !inflight && (seq || (run && pend != '0 && !sleep_enter && !sleep_pend));
  assign sr_drive = (st == S_SR);
  assign ready    = run;

  wire take     = ref_req && ref_gnt;
  wire fin      = inflight && ref_done;
  wire tick     = (ival == IW'(REF_INTERVAL - 1));
  wire hold_ok  = (cnt >= CW'(SR_HOLD - 1));
  wire go_sleep = run && (sleep_enter || sleep_pend) && !inflight;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      ival <= '0;
      stale <= '0;
      pend <= '0;
      inflight <= 1'b0;
      sleep_pend <= 1'b0;
      exit_pend <= 1'b0;
    end else begin
      if (take) inflight <= 1'b1;
      else if (fin) inflight <= 1'b0;

      case (st)
        S_IDLE: if (pwr_start) begin
          st <= S_PWAIT;
          cnt <= '0;
        end
        S_PWAIT: begin
          if (cnt == CW'(PWRUP_WAIT - 1)) begin
            st <= S_WAKE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_WAKE: if (fin) begin
          if (cnt == CW'(WAKE_CYCLES - 1)) begin
            st <= S_RUN;
            ival <= '0;
            pend <= '0;
            stale <= '0;
            sleep_pend <= 1'b0;
          end else cnt <= cnt + 1'b1;
        end
        S_RUN: begin
          if (go_sleep) begin
            st <= S_SR;
            cnt <= '0;
            sleep_pend <= 1'b0;
            exit_pend <= 1'b0;
          end else begin
            if (sleep_enter) sleep_pend <= 1'b1;
            if (stale == SW'(STALE_LIMIT - 1)) begin
              st <= S_WAKE;
              cnt <= '0;
              sleep_pend <= 1'b0;
            end else stale <= fin ? '0 : stale + 1'b1;
            if (take) begin
              ival <= '0;
              pend <= pend - 1'b1;
            end else if (tick) begin
              ival <= '0;
              if (pend != PW'(PEND_MAX)) pend <= pend + 1'b1;
            end else ival <= ival + 1'b1;
          end
        end
        S_SR: begin
          if (sleep_exit) exit_pend <= 1'b1;
          if (!hold_ok) cnt <= cnt + 1'b1;
          if (hold_ok && (exit_pend || sleep_exit)) begin
            st <= S_EXREC;
            cnt <= '0;
          end
        end
        S_EXREC: begin
          if (cnt == CW'(EXIT_RECOVER - 1)) begin
            cnt <= '0;
            if (exit_burst) st <= S_BURST;
            else begin
              st <= S_RUN;
              ival <= '0;
              pend <= '0;
              stale <= '0;
              sleep_pend <= 1'b0;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_BURST: if (fin) begin
          if (cnt == CW'(ROWS - 1)) begin
            st <= S_RUN;
            ival <= '0;
            pend <= '0;
            stale <= '0;
            sleep_pend <= 1'b0;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_quiet_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PWAIT) |-> !ref_req && !ready);
  a_r3_req_drops_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !ref_req);
  a_r5_pend_cap: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= PW'(PEND_MAX));
  a_r7_sr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    sr_drive |-> !ref_req && !ready);
  a_r8_clean_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_drive) |-> $past(st) == S_RUN && !$past(inflight));
  a_r9_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_drive) |-> $past(cnt) == CW'(SR_HOLD - 1));
  a_r10_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_drive) |-> !ready && !ref_req);
endmodule

// File: tb/dram_refresh_seq_tb.sv
module dram_refresh_seq_tb;
  localparam int ROWS = 16, WK = 8, PW = 5, IV = 10, PM = 8, SL = 150, SH = 6, ER = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwr_start = 0, sleep_enter = 0, sleep_exit = 0, exit_burst = 0, ref_gnt = 0, ref_done = 0;
  logic ref_req, sr_drive, ready;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  dram_refresh_seq #(.ROWS(ROWS), .WAKE_CYCLES(WK), .PWRUP_WAIT(PW), .REF_INTERVAL(IV),
    .PEND_MAX(PM), .STALE_LIMIT(SL), .SR_HOLD(SH), .EXIT_RECOVER(ER)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_start(pwr_start), .sleep_enter(sleep_enter),
    .sleep_exit(sleep_exit), .exit_burst(exit_burst), .ref_gnt(ref_gnt), .ref_done(ref_done),
    .ref_req(ref_req), .sr_drive(sr_drive), .ready(ready));

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic serve(input int n);
    for (int i = 0; i < n; i++) begin
      for (int g = 0; g < 1000 && !ref_req; g++) step();
      ref_gnt = 1; step(); ref_gnt = 0;
      step();
      ref_done = 1; step(); ref_done = 0;
    end
  endtask

  int k;

  initial begin
    repeat (3) step();
    rst_n = 1;
    repeat (5) step();
    chk("R1 ready", ready, 0); chk("R1 ref_req", ref_req, 0); chk("R1 sr_drive", sr_drive, 0);

    pwr_start = 1; step(); pwr_start = 0;
    k = 0;
    while (!ref_req && k < 1000) begin step(); k++; end
    chk("R2 wait cycles", k, PW);
    serve(WK - 1);
    chk("R2 ready before last", ready, 0);
    serve(1);
    chk("R2 ready after wake", ready, 1);

    k = 0;
    while (!ref_req && k < 1000) begin step(); k++; end
    chk("R4 first interval", k, IV);
    repeat (3) step();
    chk("R3 req held without grant", ref_req, 1);
    ref_gnt = 1; step(); ref_gnt = 0;
    step();
    chk("R3 req low in flight", ref_req, 0);
    ref_done = 1; step(); ref_done = 0;
    k = 2;
    while (!ref_req && k < 1000) begin step(); k++; end
    chk("R4 interval after grant", k, IV);

    repeat (10 * IV) step();
    k = 0;
    while (ref_req && k < 100) begin serve(1); k++; end
    chk("R5 saturated count", k, PM);

    k = 0;
    while (ready && k < 1000) begin step(); k++; end
    chk("R6 stale limit", k, SL);
    sleep_enter = 1; step(); sleep_enter = 0;
    chk("R12 enter ignored in wake", sr_drive, 0);
    serve(WK - 1);
    chk("R6 not ready mid wake", ready, 0);
    serve(1);
    chk("R6 ready after rewake", ready, 1);
    chk("R12 no late sleep", sr_drive, 0);

    exit_burst = 0;
    sleep_enter = 1; step(); sleep_enter = 0;
    chk("R7 sr_drive", sr_drive, 1); chk("R7 ready", ready, 0); chk("R7 ref_req", ref_req, 0);
    sleep_exit = 1; step(); sleep_exit = 0;
    k = 1;
    while (sr_drive && k < 1000) begin step(); k++; end
    chk("R9 hold length", k, SH);
    k = 0;
    while (!ready && k < 1000) begin
      if (ref_req) chk("R10 no req in recovery", 1, 0);
      step(); k++;
    end
    chk("R10 recovery", k, ER);

    sleep_exit = 1; step(); sleep_exit = 0;
    chk("R12 exit ignored sr", sr_drive, 0); chk("R12 exit ignored ready", ready, 1);

    for (int g = 0; g < 1000 && !ref_req; g++) step();
    ref_gnt = 1; step(); ref_gnt = 0;
    sleep_enter = 1; step(); sleep_enter = 0;
    chk("R8 deferred", sr_drive, 0);
    ref_done = 1; step(); ref_done = 0;
    chk("R8 still deferred", sr_drive, 0);
    step();
    chk("R8 entered after done", sr_drive, 1);

    exit_burst = 1;
    sleep_exit = 1; step(); sleep_exit = 0;
    for (int g = 0; g < 1000 && sr_drive; g++) step();
    k = 0;
    while (!ref_req && k < 1000) begin step(); k++; end
    chk("R10 recovery before burst", k, ER);
    serve(ROWS - 1);
    chk("R11 not ready mid burst", ready, 0);
    serve(1);
    chk("R11 ready after burst", ready, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule